// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a request scheduler and a DRAM rank of eight independent banks. It takes one read or write request at a time and turns it into device commands. What it emits depends on the row state of the target bank. A bank with no open row receives an activate and then the column command. A bank whose open row matches the request receives only the column command. A bank holding a different row receives a precharge, an activate and then the column command. Each bank remembers its own open row and runs its own countdown, so activity in one bank leaves the others untouched.

Each bank has its own precharge, activate-to-column and read latency values, and these can change while the block runs. The sequencer copies the target bank's three values when it accepts a request, and uses that copy for the whole command sequence. A refresh request takes precedence over new requests. The block closes every open bank one precharge at a time, waits until each bank's precharge time has elapsed, issues the refresh, and then stays silent for a lockout whose length in cycles is a build parameter. A completion pulse marks the end of each request: it comes with the write command, or a read-latency number of cycles after the read command.

Top module: `rank_cmd_sequencer`

## Requirements
- R1: After reset, no command is driven (`cmdValid`=0, `cmdType`=0), `doneValid` and `refAck` are 0, every bank is closed and `reqReady` is 1.
- R2: A request to a closed bank produces ACT (`cmdType`=2, `cmdAddr`=row) one cycle after acceptance, then the column command exactly tRCD cycles after the ACT.
- R3: A request whose row equals the bank's open row produces only the column command, one cycle after acceptance.
- R4: A request to a bank holding another row produces PRE (`cmdType`=1) one cycle after acceptance, ACT exactly tRP cycles later, and the column command exactly tRCD cycles after the ACT. A column command never directly follows a PRE.
- R5: `doneValid` pulses for one cycle: in the same cycle as WR (`cmdType`=4) for writes, and exactly tCL cycles after RD (`cmdType`=3) for reads.
- R6: The tRP, tRCD and tCL values that apply to a request are the ones present on the target bank's timing slice (`bankX[b*T_W +: T_W]`) in the accepting cycle. Later changes to those inputs do not alter that request's spacing.
- R7: While `refReq` is high in the idle state, open banks are precharged one per cycle in ascending bank order. REF (`cmdType`=5, `refAck`=1) follows once no bank is open and every precharged bank has completed its live tRP. With nothing open, REF comes two cycles after `refReq` rises.
- R8: For TRFC_CYC cycles after REF, no command is driven, and `reqReady` returns exactly TRFC_CYC cycles after REF.
- R9: After a refresh, every bank is closed, so a request to a row that was previously open starts with ACT.
- R10: Opening, hitting or closing a row in one bank does not change the open row of any other bank.
- R11: At most one command is driven per cycle. `cmdValid` is 1 exactly when `cmdType` is not 0. `cmdBank` carries the request's bank, and `cmdAddr` carries the row on ACT and the column on RD and WR.
- R12: `reqReady` is 1 only in the idle state while `refReq` is low. A request is taken on a clock edge where `reqValid` and `reqReady` are both 1. No command is driven in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The sequencer can take a request this cycle |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqWrite | input | 1 | 1 for write, 0 for read |
| doneValid | output | 1 | The request has completed (one-cycle pulse) |
| refReq | input | 1 | Refresh wanted; hold until refAck |
| refAck | output | 1 | Pulses with the REF command |
| bankTrp | input | NUM_BANKS*T_W | Per-bank precharge time in cycles |
| bankTrcd | input | NUM_BANKS*T_W | Per-bank activate-to-column time in cycles |
| bankTcl | input | NUM_BANKS*T_W | Per-bank read latency in cycles |
| cmdValid | output | 1 | A command is driven this cycle |
| cmdType | output | 3 | 0 none, 1 PRE, 2 ACT, 3 RD, 4 WR, 5 REF |
| cmdBank | output | BANK_W | Bank of the command |
| cmdAddr | output | max(ROW_W,COL_W) | Row for ACT, column for RD and WR |

## Verification
The bench builds the block with eight banks, 14-bit rows, 10-bit columns, 6-bit timing fields and a refresh lockout of 12 cycles. The short lockout lets every cycle of the silent window and the exact return of `reqReady` be checked one by one. Each bank gets a different tRP, tRCD and tCL, so a wrong bank index in the timing lookup, or a spacing that comes from the wrong bank, produces a visibly wrong gap. A refresh with three banks open uses three different live precharge times, and that fixes exactly when REF must appear.

// File: rtl/rank_seq_pkg.sv
package rank_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // control -> datapath
  typedef struct packed {
    logic latchReq;
    logic doPre;
    logic doAct;
    logic doCol;
    logic doRefPre;
    logic doRef;
    logic doneNow;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic curReady;
    logic curOpen;
    logic curHit;
    logic curWrite;
    logic refPreAvail;
    logic allQuiet;
    logic dataEnd;
    logic lockEnd;
  } status_t;

endpackage

// File: rtl/rank_bank_slot.sv
module rank_bank_slot #(
  parameter int ROW_W = 14,
  parameter int T_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre,
  input  logic             act,
  input  logic [ROW_W-1:0] actRow,
  input  logic [T_W-1:0]   loadVal,
  output logic             isOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             ready
);

  logic [T_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waitCnt <= '0;
      isOpen  <= 1'b0;
      openRow <= '0;
    end else begin
      if (pre || act) begin
        waitCnt <= loadVal;
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - T_W'(1);
      end
      if (act) begin
        isOpen  <= 1'b1;
        openRow <= actRow;
      end else if (pre) begin
        isOpen <= 1'b0;
      end
    end
  end

  // a load of N lets the next command go N cycles later
  assign ready = (waitCnt < T_W'(2));

endmodule

// File: rtl/rank_seq_control.sv
module rank_seq_control
  import rank_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    refReq,
  input  status_t stat,
  output strobe_t stb,
  output logic    reqReady
);

  typedef enum logic [2:0] {
    S_IDLE, S_SEQ, S_DATA, S_REFPRE, S_LOCK
  } state_e;

  state_e state, nxtState;

  always_comb begin
    stb      = '0;
    nxtState = state;
    case (state)
      S_IDLE: begin
        if (refReq) begin
          nxtState = S_REFPRE;
        end else if (reqValid) begin
          stb.latchReq = 1'b1;
          nxtState     = S_SEQ;
        end
      end
      S_SEQ: begin
        if (stat.curReady) begin
          if (stat.curOpen && stat.curHit) begin
            stb.doCol = 1'b1;
            if (stat.curWrite) begin
              stb.doneNow = 1'b1;
              nxtState    = S_IDLE;
            end else begin
              nxtState = S_DATA;
            end
          end else if (stat.curOpen) begin
            stb.doPre = 1'b1;
          end else begin
            stb.doAct = 1'b1;
          end
        end
      end
      S_DATA: begin
        if (stat.dataEnd) begin
          stb.doneNow = 1'b1;
          nxtState    = S_IDLE;
        end
      end
      S_REFPRE: begin
        if (stat.allQuiet) begin
          stb.doRef = 1'b1;
          nxtState  = S_LOCK;
        end else if (stat.refPreAvail) begin
          stb.doRefPre = 1'b1;
        end
      end
      S_LOCK: begin
        if (stat.lockEnd) nxtState = S_IDLE;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxtState;
  end

  assign reqReady = (state == S_IDLE) && !refReq;

endmodule

// File: rtl/rank_seq_datapath.sv
module rank_seq_datapath
  import rank_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_W       = 6,
  parameter int TRFC_CYC  = 240,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int RC_W     = $clog2(TRFC_CYC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  stb,
  input  logic [BANK_W-1:0]        reqBank,
  input  logic [ROW_W-1:0]         reqRow,
  input  logic [COL_W-1:0]         reqCol,
  input  logic                     reqWrite,
  input  logic [NUM_BANKS*T_W-1:0] bankTrp,
  input  logic [NUM_BANKS*T_W-1:0] bankTrcd,
  input  logic [NUM_BANKS*T_W-1:0] bankTcl,
  output status_t                  stat,
  output logic                     cmdValid,
  output cmd_e                     cmdType,
  output logic [BANK_W-1:0]        cmdBank,
  output logic [ADDR_W-1:0]        cmdAddr,
  output logic                     doneValid,
  output logic                     refAck
);

  logic [T_W-1:0]   trpArr  [NUM_BANKS];
  logic [T_W-1:0]   trcdArr [NUM_BANKS];
  logic [T_W-1:0]   tclArr  [NUM_BANKS];

  logic [BANK_W-1:0] latBank;
  logic [ROW_W-1:0]  latRow;
  logic [COL_W-1:0]  latCol;
  logic              latWrite;
  logic [T_W-1:0]    latTrp, latTrcd, latTcl;

  logic [NUM_BANKS-1:0] slotPre, slotAct, slotOpen, slotReady;
  logic [T_W-1:0]       slotLoad [NUM_BANKS];
  logic [ROW_W-1:0]     slotRow  [NUM_BANKS];

  logic [BANK_W-1:0] refSel;
  logic              refFound;
  logic [T_W-1:0]    dataCnt;
  logic [RC_W-1:0]   refCnt;

  // request capture, including the target bank's timing set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latBank  <= '0;
      latRow   <= '0;
      latCol   <= '0;
      latWrite <= 1'b0;
      latTrp   <= '0;
      latTrcd  <= '0;
      latTcl   <= '0;
    end else if (stb.latchReq) begin
      latBank  <= reqBank;
      latRow   <= reqRow;
      latCol   <= reqCol;
      latWrite <= reqWrite;
      latTrp   <= trpArr[reqBank];
      latTrcd  <= trcdArr[reqBank];
      latTcl   <= tclArr[reqBank];
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign trpArr[i]  = bankTrp[i*T_W +: T_W];
    assign trcdArr[i] = bankTrcd[i*T_W +: T_W];
    assign tclArr[i]  = bankTcl[i*T_W +: T_W];

    assign slotPre[i] = (stb.doPre && (latBank == BANK_W'(i))) ||
                        (stb.doRefPre && (refSel == BANK_W'(i)));
    assign slotAct[i] = stb.doAct && (latBank == BANK_W'(i));
    assign slotLoad[i] = stb.doRefPre ? trpArr[i] :
                         (stb.doPre ? latTrp : latTrcd);

    rank_bank_slot #(.ROW_W(ROW_W), .T_W(T_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .pre     (slotPre[i]),
      .act     (slotAct[i]),
      .actRow  (latRow),
      .loadVal (slotLoad[i]),
      .isOpen  (slotOpen[i]),
      .openRow (slotRow[i]),
      .ready   (slotReady[i])
    );
  end

  // lowest open bank whose countdown allows a precharge
  always_comb begin
    refSel   = '0;
    refFound = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (slotOpen[i] && slotReady[i]) begin
        refSel   = BANK_W'(i);
        refFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataCnt <= '0;
      refCnt  <= '0;
    end else begin
      if (stb.doCol && !latWrite) dataCnt <= latTcl;
      else if (dataCnt != '0)     dataCnt <= dataCnt - T_W'(1);
      if (stb.doRef)              refCnt <= RC_W'(TRFC_CYC);
      else if (refCnt != '0)      refCnt <= refCnt - RC_W'(1);
    end
  end

  always_comb begin
    stat.curReady    = slotReady[latBank];
    stat.curOpen     = slotOpen[latBank];
    stat.curHit      = (slotRow[latBank] == latRow);
    stat.curWrite    = latWrite;
    stat.refPreAvail = refFound;
    stat.allQuiet    = (slotOpen == '0) && (&slotReady);
    stat.dataEnd     = (dataCnt < T_W'(2));
    stat.lockEnd     = (refCnt < RC_W'(2));
  end

  // registered command bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdValid  <= 1'b0;
      cmdType   <= CMD_NOP;
      cmdBank   <= '0;
      cmdAddr   <= '0;
      doneValid <= 1'b0;
      refAck    <= 1'b0;
    end else begin
      cmdValid  <= 1'b0;
      cmdType   <= CMD_NOP;
      cmdBank   <= '0;
      cmdAddr   <= '0;
      doneValid <= stb.doneNow;
      refAck    <= stb.doRef;
      if (stb.doPre) begin
        cmdValid <= 1'b1;
        cmdType  <= CMD_PRE;
        cmdBank  <= latBank;
      end else if (stb.doRefPre) begin
        cmdValid <= 1'b1;
        cmdType  <= CMD_PRE;
        cmdBank  <= refSel;
      end else if (stb.doAct) begin
        cmdValid <= 1'b1;
        cmdType  <= CMD_ACT;
        cmdBank  <= latBank;
        cmdAddr  <= ADDR_W'(latRow);
      end else if (stb.doCol) begin
        cmdValid <= 1'b1;
        cmdType  <= latWrite ? CMD_WR : CMD_RD;
        cmdBank  <= latBank;
        cmdAddr  <= ADDR_W'(latCol);
      end else if (stb.doRef) begin
        cmdValid <= 1'b1;
        cmdType  <= CMD_REF;
      end
    end
  end

endmodule

// File: rtl/rank_cmd_sequencer.sv
module rank_cmd_sequencer
  import rank_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_W       = 6,
  parameter int TRFC_CYC  = 240,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [BANK_W-1:0]        reqBank,
  input  logic [ROW_W-1:0]         reqRow,
  input  logic [COL_W-1:0]         reqCol,
  input  logic                     reqWrite,
  output logic                     doneValid,
  input  logic                     refReq,
  output logic                     refAck,
  input  logic [NUM_BANKS*T_W-1:0] bankTrp,
  input  logic [NUM_BANKS*T_W-1:0] bankTrcd,
  input  logic [NUM_BANKS*T_W-1:0] bankTcl,
  output logic                     cmdValid,
  output logic [2:0]               cmdType,
  output logic [BANK_W-1:0]        cmdBank,
  output logic [ADDR_W-1:0]        cmdAddr
);

  strobe_t stb;
  status_t stat;
  cmd_e    cmdTypeE;

  rank_seq_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .refReq   (refReq),
    .stat     (stat),
    .stb      (stb),
    .reqReady (reqReady)
  );

  rank_seq_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .T_W       (T_W),
    .TRFC_CYC  (TRFC_CYC)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .reqBank   (reqBank),
    .reqRow    (reqRow),
    .reqCol    (reqCol),
    .reqWrite  (reqWrite),
    .bankTrp   (bankTrp),
    .bankTrcd  (bankTrcd),
    .bankTcl   (bankTcl),
    .stat      (stat),
    .cmdValid  (cmdValid),
    .cmdType   (cmdTypeE),
    .cmdBank   (cmdBank),
    .cmdAddr   (cmdAddr),
    .doneValid (doneValid),
    .refAck    (refAck)
  );

  assign cmdType = cmdTypeE;

endmodule

// File: rtl/rank_seq_checker.sv
module rank_seq_checker #(
  parameter int TRFC_CYC = 240
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       reqReady,
  input logic       refReq,
  input logic       refAck,
  input logic       doneValid,
  input logic       cmdValid,
  input logic [2:0] cmdType
);

  int lockLeft;

  always_ff @(posedge clk) begin
    if (!rst_n)                             lockLeft <= 0;
    else if (cmdValid && cmdType == 3'd5)   lockLeft <= TRFC_CYC - 1;
    else if (lockLeft > 0)                  lockLeft <= lockLeft - 1;
  end

  // R11
  cmd_type_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid == (cmdType != 3'd0));

  // R8
  refresh_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockLeft > 0) |-> !cmdValid);

  // R12
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !cmdValid);

  // R12
  refresh_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refReq |-> !reqReady);

  // R5
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdType == 3'd4) |-> doneValid);

  // R4
  pre_no_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdType == 3'd1) |=> !(cmdValid && (cmdType == 3'd3 || cmdType == 3'd4)));

  // R7
  ref_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refAck == (cmdValid && cmdType == 3'd5));

endmodule

bind rank_cmd_sequencer rank_seq_checker #(.TRFC_CYC(TRFC_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .refReq    (refReq),
  .refAck    (refAck),
  .doneValid (doneValid),
  .cmdValid  (cmdValid),
  .cmdType   (cmdType)
);

// File: tb/rank_cmd_sequencer_test.sv
module rank_cmd_sequencer_test;

  localparam int NB    = 8;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int T_W   = 6;
  localparam int TRFC  = 12;
  localparam int BW    = 3;
  localparam int AW    = 14;

  localparam int K_HIT    = 0;
  localparam int K_MISS   = 1;
  localparam int K_CLOSED = 2;

  typedef struct packed {
    logic [2:0]  b;
    logic [13:0] r;
    logic [9:0]  c;
    logic        w;
    logic [1:0]  k;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 14'd5,   10'd3, 1'b0, 2'd2},
    '{3'd0, 14'd5,   10'd7, 1'b1, 2'd0},
    '{3'd0, 14'd9,   10'd1, 1'b0, 2'd1},
    '{3'd3, 14'd2,   10'd4, 1'b1, 2'd2},
    '{3'd0, 14'd9,   10'd2, 1'b0, 2'd0},
    '{3'd3, 14'd2,   10'd5, 1'b0, 2'd0},
    '{3'd7, 14'd100, 10'd8, 1'b0, 2'd2},
    '{3'd3, 14'd6,   10'd9, 1'b1, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [BW-1:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic reqWrite = 1'b0;
  logic doneValid;
  logic refReq = 1'b0;
  logic refAck;
  logic [NB*T_W-1:0] bankTrp, bankTrcd, bankTcl;
  logic cmdValid;
  logic [2:0] cmdType;
  logic [BW-1:0] cmdBank;
  logic [AW-1:0] cmdAddr;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int wd = 0;
  bit modelOpen [NB];

  rank_cmd_sequencer #(
    .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .T_W(T_W), .TRFC_CYC(TRFC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite),
    .doneValid(doneValid), .refReq(refReq), .refAck(refAck),
    .bankTrp(bankTrp), .bankTrcd(bankTrcd), .bankTcl(bankTcl),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      testCnt++;
      failCnt++;
      $display("FAIL R12 watchdog: cycles=%0d expected<=%0d", wd, 20000);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  function automatic int fTrp(int b);  return 2 + (b & 1) + (b >> 2); endfunction
  function automatic int fTrcd(int b); return 3 + (b & 1);            endfunction
  function automatic int fTcl(int b);  return 2 + (b % 3);            endfunction

  task automatic setTiming(input int b, input int rp, input int rcd, input int cl);
    bankTrp[b*T_W +: T_W]  = T_W'(rp);
    bankTrcd[b*T_W +: T_W] = T_W'(rcd);
    bankTcl[b*T_W +: T_W]  = T_W'(cl);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one request; expected sequence from the bank state the bench models
  task automatic runReq(input int b, input int row, input int col, input bit wr,
                        input int kind, input bit bumpTiming);
    int tyA [4]; int stA [4]; int bkA [4]; int adA [4];
    int tyE [4]; int stE [4];
    int nA, nE, a, doneAt, t, rp, rcd, cl, badIdx;
    string tag;
    rp = fTrp(b); rcd = fTrcd(b); cl = fTcl(b);
    reqBank = BW'(b); reqRow = ROW_W'(row); reqCol = COL_W'(col); reqWrite = wr;
    reqValid = 1'b1;
    while (!reqReady) step();
    step();
    a = cyc;
    reqValid = 1'b0;
    if (bumpTiming) setTiming(b, 20, 20, 20);
    nA = 0; doneAt = -1;
    for (int k = 0; k < 120; k++) begin
      step();
      if (cmdValid && nA < 4) begin
        tyA[nA] = cmdType; stA[nA] = cyc; bkA[nA] = cmdBank; adA[nA] = cmdAddr; nA++;
      end
      if (doneValid) begin doneAt = cyc; break; end
    end
    t = a + 1; nE = 0;
    if (kind == K_MISS) begin
      tyE[nE] = 1; stE[nE] = t; nE++; t += rp;
    end
    if (kind != K_HIT) begin
      tyE[nE] = 2; stE[nE] = t; nE++; t += rcd;
    end
    tyE[nE] = wr ? 4 : 3; stE[nE] = t; nE++;
    tag = (kind == K_HIT) ? "R3" : ((kind == K_MISS) ? "R4" : "R2");
    if (bumpTiming) tag = "R6";
    badIdx = -1;
    for (int i = 0; i < nE; i++)
      if (i >= nA || tyA[i] != tyE[i] || stA[i] != stE[i]) begin badIdx = i; break; end
    if (badIdx < 0 && nA != nE) badIdx = nE;
    if (badIdx < 0) check(1'b1, tag, "sequence", 0, 0);
    else if (badIdx >= nA) check(1'b0, tag, "command count", nA, nE);
    else if (badIdx >= nE) check(1'b0, tag, "extra command", nA, nE);
    else begin
      check(tyA[badIdx] == tyE[badIdx], tag, $sformatf("type of cmd %0d", badIdx),
            tyA[badIdx], tyE[badIdx]);
      check(stA[badIdx] == stE[badIdx], tag, $sformatf("cycle of cmd %0d", badIdx),
            stA[badIdx] - a, stE[badIdx] - a);
    end
    check(doneAt == (wr ? t : t + cl), "R5", "done cycle after accept",
          doneAt - a, (wr ? t : t + cl) - a);
    for (int i = 0; i < nA; i++) begin
      check(bkA[i] == b, "R11", "command bank", bkA[i], b);
      if (tyA[i] == 2) check(adA[i] == row, "R11", "ACT row", adA[i], row);
      if (tyA[i] == 3 || tyA[i] == 4) check(adA[i] == col, "R11", "column addr", adA[i], col);
    end
    modelOpen[b] = 1'b1;
    if (bumpTiming) setTiming(b, fTrp(b), fTrcd(b), fTcl(b));
  endtask

  task automatic doRefresh(input bit withReq);
    int s, refAt, expRef, nPre, readyBad, otherCmds, lockCmds, lockReadyBad;
    int preBk [NB]; int preSt [NB]; int expBk [NB]; int expSt [NB]; int nExp;
    s = cyc;
    refReq = 1'b1;
    if (withReq) begin
      reqBank = 3'd0; reqRow = 14'd9; reqCol = 10'd4; reqWrite = 1'b0; reqValid = 1'b1;
    end
    nExp = 0; expRef = s + 2;
    for (int b = 0; b < NB; b++) if (modelOpen[b]) begin
      expBk[nExp] = b; expSt[nExp] = s + 2 + nExp;
      if (expSt[nExp] + fTrp(b) > expRef) expRef = expSt[nExp] + fTrp(b);
      nExp++;
    end
    nPre = 0; refAt = -1; readyBad = 0; otherCmds = 0;
    for (int k = 0; k < 80; k++) begin
      step();
      if (reqReady) readyBad++;
      if (cmdValid) begin
        if (cmdType == 3'd1 && nPre < NB) begin
          preBk[nPre] = cmdBank; preSt[nPre] = cyc; nPre++;
        end else if (cmdType == 3'd5) begin
          refAt = cyc; break;
        end else otherCmds++;
      end
    end
    check(nPre == nExp, "R7", "precharges before REF", nPre, nExp);
    for (int i = 0; i < nPre && i < nExp; i++) begin
      check(preBk[i] == expBk[i], "R7", "precharge bank order", preBk[i], expBk[i]);
      check(preSt[i] == expSt[i], "R7", "precharge cycle", preSt[i] - s, expSt[i] - s);
    end
    check(refAt == expRef, "R7", "REF cycle after refReq", refAt - s, expRef - s);
    check(refAck == 1'b1, "R7", "refAck with REF", refAck, 1);
    check(otherCmds == 0, "R7", "non-precharge commands before REF", otherCmds, 0);
    check(readyBad == 0, "R12", "reqReady high during refresh", readyBad, 0);
    refReq = 1'b0;
    lockCmds = 0; lockReadyBad = 0;
    for (int j = 1; j <= TRFC; j++) begin
      step();
      if (cmdValid) lockCmds++;
      if (reqReady != (j == TRFC)) lockReadyBad++;
    end
    check(lockCmds == 0, "R8", "commands during lockout", lockCmds, 0);
    check(lockReadyBad == 0, "R8", "reqReady timing mismatches", lockReadyBad, 0);
    for (int b = 0; b < NB; b++) modelOpen[b] = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      setTiming(b, fTrp(b), fTrcd(b), fTcl(b));
      modelOpen[b] = 1'b0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(cmdValid == 1'b0, "R1", "cmdValid after reset", cmdValid, 0);
    check(cmdType == 3'd0, "R1", "cmdType after reset", cmdType, 0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
    check(refAck == 1'b0, "R1", "refAck after reset", refAck, 0);
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);

    // R7 refresh with no bank open
    doRefresh(1'b0);

    // table walk: closed, hit, miss in several banks (R10 via interleaving)
    for (int v = 0; v < 8; v++) begin
      runReq(VECS[v].b, VECS[v].r, VECS[v].c, VECS[v].w, VECS[v].k, 1'b0);
      step();
    end
    // R10: bank 0 still holds row 9 after bank 3 and bank 7 traffic
    runReq(0, 9, 6, 1'b1, K_HIT, 1'b0);
    step();

    // R6: timing inputs change right after acceptance
    runReq(7, 200, 11, 1'b0, K_MISS, 1'b1);
    step();

    // R7 refresh with banks 0, 3, 7 open and a request waiting
    doRefresh(1'b1);
    // R9: previously open row now needs an activate
    runReq(0, 9, 4, 1'b0, K_CLOSED, 1'b0);
    step();

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule